// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block is a direct-mapped next-PC predictor for the fetch stage. Each fetch cycle it is given the current fetch address. In the same cycle it reports whether a stored entry belongs to that address, the target address kept in that entry, and a taken/not-taken guess from a 2-bit saturating counter held in the entry. From these it computes the next fetch address. The stored target is used only when the entry matches and its counter predicts taken. In every other case the next address is the fetch address plus 4.

The table is an array of registers with 2^IDX_W entries. It is selected by the word-address bits [IDX_W+1:2] of the PC. Each entry keeps the complete branch address as its tag, so a target that belongs to another branch is never returned. A single feedback port reports resolved branches, either when a misprediction is found or when a branch commits. That port trains the counter, refreshes the stored target, and allocates a new entry for a taken branch that is not yet in the table.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every entry, so after reset every lookup reports no hit, not taken, and next_pc = fetch_pc + 4.
- R2: A taken update for an address with no entry allocates that address's entry. From the following cycle, a lookup of that address hits, predicts taken and yields the reported target as next_pc.
- R3: A not-taken update for an address with no entry changes nothing, and later lookups of that address still miss.
- R4: A lookup whose index bits [IDX_W+1:2] match an entry but whose full address differs from the stored tag reports no hit and next_pc = fetch_pc + 4.
- R5: On an update that hits, the counter is 2 bits (00, 01 predict not taken; 10, 11 predict taken). A taken outcome increments it, saturating at 11. A not-taken outcome decrements it, saturating at 00. From 11, two not-taken outcomes are needed to flip the prediction.
- R6: A hit whose counter is 00 or 01 reports hit = 1, taken = 0 and next_pc = fetch_pc + 4.
- R7: A taken update that hits replaces the stored target, and the new target is used from the next cycle.
- R8: Updates take effect at the next clock edge. A lookup in the same cycle as an update to the same index sees the contents from before the update.
- R9: A taken update that misses an index held by another address evicts that entry. It writes the new tag and target and sets the counter to 10 (weakly taken).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | ADDR_W | Current fetch address |
| pred_hit | output | 1 | An entry with a matching tag exists |
| pred_taken | output | 1 | Hit and counter predicts taken |
| pred_target | output | ADDR_W | Stored target of the matching entry (zero on a miss) |
| next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The hardest state to reach is counter hysteresis at the saturated ends. The bench has to walk one entry from weakly taken down to 00, back up through 01 to 11, and then apply single not-taken outcomes, with a lookup after each step to show the counter's effect at the ports. The bench issues a long run of updates to a single address and interleaves lookups at each step. It also places a lookup in the same cycle as an update, which shows the pre-update contents. Conflict eviction is reached by allocating a second address with the same index bits.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_ON_ALLOC = CTR_WEAK_T;
    localparam int   PC_STEP      = 4;
    localparam int   ALIGN_BITS   = 2;

    function automatic ctr_e ctr_train(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_tag,
    output logic [ADDR_W-1:0] rd_target,
    output ctr_e              rd_ctr,
    input  logic [IDX_W-1:0]  tr_idx,
    output logic              tr_valid,
    output logic [ADDR_W-1:0] tr_tag,
    output logic [ADDR_W-1:0] tr_target,
    output ctr_e              tr_ctr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    input  ctr_e              wr_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    logic              valid_q  [DEPTH];
    logic [ADDR_W-1:0] tag_q    [DEPTH];
    logic [ADDR_W-1:0] target_q [DEPTH];
    ctr_e              ctr_q    [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[e] <= 1'b0;
            end else if (sel) begin
                valid_q[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[e]    <= wr_tag;
                target_q[e] <= wr_target;
                ctr_q[e]    <= wr_ctr;
            end
        end
    end

    assign rd_valid  = valid_q[rd_idx];
    assign rd_tag    = tag_q[rd_idx];
    assign rd_target = target_q[rd_idx];
    assign rd_ctr    = ctr_q[rd_idx];

    assign tr_valid  = valid_q[tr_idx];
    assign tr_tag    = tag_q[tr_idx];
    assign tr_target = target_q[tr_idx];
    assign tr_ctr    = ctr_q[tr_idx];

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              ent_valid,
    input  logic [ADDR_W-1:0] ent_tag,
    input  logic [ADDR_W-1:0] ent_target,
    input  ctr_e              ent_ctr,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] next_pc
);
    always_comb begin
        hit     = ent_valid && (ent_tag == pc);
        taken   = hit && ctr_says_taken(ent_ctr);
        target  = hit ? ent_target : '0;
        next_pc = taken ? ent_target : pc + ADDR_W'(PC_STEP);
    end
endmodule

// File: rtl/btb_train.sv
module btb_train
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              ent_valid,
    input  logic [ADDR_W-1:0] ent_tag,
    input  logic [ADDR_W-1:0] ent_target,
    input  ctr_e              ent_ctr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_tag,
    output logic [ADDR_W-1:0] wr_target,
    output ctr_e              wr_ctr
);
    logic match;

    always_comb begin
        match     = ent_valid && (ent_tag == upd_pc);
        wr_en     = 1'b0;
        wr_tag    = upd_pc;
        wr_target = ent_target;
        wr_ctr    = ent_ctr;
        if (upd_valid) begin
            if (match) begin
                wr_en  = 1'b1;
                wr_ctr = ctr_train(ent_ctr, upd_taken);
                if (upd_taken) wr_target = upd_target;
            end else if (upd_taken) begin
                wr_en     = 1'b1;
                wr_target = upd_target;
                wr_ctr    = CTR_ON_ALLOC;
            end
        end
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic [ADDR_W-1:0] next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    localparam int IDX_LO = ALIGN_BITS;
    localparam int IDX_HI = ALIGN_BITS + IDX_W - 1;

    logic [IDX_W-1:0]  look_idx, upd_idx;
    logic              rd_valid, tr_valid, wr_en;
    logic [ADDR_W-1:0] rd_tag, rd_target, tr_tag, tr_target, wr_tag, wr_target;
    ctr_e              rd_ctr, tr_ctr, wr_ctr;

    assign look_idx = fetch_pc[IDX_HI:IDX_LO];
    assign upd_idx  = upd_pc[IDX_HI:IDX_LO];

    btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (look_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_target (rd_target),
        .rd_ctr    (rd_ctr),
        .tr_idx    (upd_idx),
        .tr_valid  (tr_valid),
        .tr_tag    (tr_tag),
        .tr_target (tr_target),
        .tr_ctr    (tr_ctr),
        .wr_en     (wr_en),
        .wr_idx    (upd_idx),
        .wr_tag    (wr_tag),
        .wr_target (wr_target),
        .wr_ctr    (wr_ctr)
    );

    btb_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .pc         (fetch_pc),
        .ent_valid  (rd_valid),
        .ent_tag    (rd_tag),
        .ent_target (rd_target),
        .ent_ctr    (rd_ctr),
        .hit        (pred_hit),
        .taken      (pred_taken),
        .target     (pred_target),
        .next_pc    (next_pc)
    );

    btb_train #(.ADDR_W(ADDR_W)) u_train (
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_target (upd_target),
        .ent_valid  (tr_valid),
        .ent_tag    (tr_tag),
        .ent_target (tr_target),
        .ent_ctr    (tr_ctr),
        .wr_en      (wr_en),
        .wr_tag     (wr_tag),
        .wr_target  (wr_target),
        .wr_ctr     (wr_ctr)
    );

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_target,
    input logic [ADDR_W-1:0] next_pc,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic [ADDR_W-1:0] upd_target
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> !pred_hit);

    assert_taken_update_installs_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && upd_valid && upd_taken) && fetch_pc == $past(upd_pc))
        |-> (pred_hit && pred_target == $past(upd_target)));

    assert_nt_miss_no_alloc_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_valid && !upd_taken && !pred_hit && fetch_pc == upd_pc)
         && fetch_pc == $past(fetch_pc))
        |-> !pred_hit);

    assert_nt_keeps_nt_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && upd_valid && !upd_taken && pred_hit && !pred_taken
               && fetch_pc == upd_pc) && fetch_pc == $past(fetch_pc))
        |-> (pred_hit && !pred_taken));

    assert_nt_hit_falls_through_R6: assert property (@(posedge clk) disable iff (rst)
        (pred_hit && !pred_taken) |-> (next_pc == fetch_pc + ADDR_W'(4)));

    assert_taken_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> pred_hit);
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_pc    (fetch_pc),
    .pred_hit    (pred_hit),
    .pred_taken  (pred_taken),
    .pred_target (pred_target),
    .next_pc     (next_pc),
    .upd_valid   (upd_valid),
    .upd_pc      (upd_pc),
    .upd_taken   (upd_taken),
    .upd_target  (upd_target)
);

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] fetch_pc = '0;
    logic          pred_hit, pred_taken;
    logic [AW-1:0] pred_target, next_pc;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;

    always #5 clk = ~clk;

    btb_predictor #(.ADDR_W(AW), .IDX_W(4)) u_btb_predictor (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken),
        .pred_target(pred_target), .next_pc(next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target)
    );

    typedef struct {
        logic [AW-1:0] pc;
        logic          hit;
        logic          taken;
        logic [AW-1:0] npc;
        string         req;
    } exp_t;

    exp_t q[$];
    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 0;

    localparam logic [AW-1:0] PA = 32'h0000_1000;
    localparam logic [AW-1:0] PB = 32'h0000_2000;
    localparam logic [AW-1:0] PC = 32'h0000_1004;

    task automatic step(input logic [AW-1:0] pc, input logic uv, input logic ut,
                        input logic [AW-1:0] upc, input logic [AW-1:0] utgt,
                        input logic chk, input logic eh, input logic et,
                        input logic [AW-1:0] en, input string rq);
        exp_t it;
        @(posedge clk);
        #1;
        fetch_pc   = pc;
        upd_valid  = uv;
        upd_taken  = ut;
        upd_pc     = upc;
        upd_target = utgt;
        if (chk) begin
            it.pc = pc; it.hit = eh; it.taken = et; it.npc = en; it.req = rq;
            q.push_back(it);
        end
    endtask

    task automatic look(input logic [AW-1:0] pc, input logic eh, input logic et,
                        input logic [AW-1:0] en, input string rq);
        step(pc, 1'b0, 1'b0, '0, '0, 1'b1, eh, et, en, rq);
    endtask

    task automatic train(input logic [AW-1:0] upc, input logic ut, input logic [AW-1:0] utgt);
        step(PC, 1'b1, ut, upc, utgt, 1'b0, 1'b0, 1'b0, '0, "");
    endtask

    // monitor: compares the combinational outputs at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            compared++;
            if (pred_hit !== it.hit || pred_taken !== it.taken || next_pc !== it.npc) begin
                mismatched++;
                $display("FAIL %s pc=%h actual hit=%0b taken=%0b next=%h expected hit=%0b taken=%0b next=%h",
                         it.req, it.pc, pred_hit, pred_taken, next_pc, it.hit, it.taken, it.npc);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            mismatched++;
            $display("FAIL watchdog (all R) actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: empty after reset
        look(PA, 0, 0, PA + 4, "R1");
        look(PC, 0, 0, PC + 4, "R1");
        // R3: not-taken miss does not allocate
        step(PA, 1, 0, PA, 32'h3000, 1, 0, 0, PA + 4, "R3");
        look(PA, 0, 0, PA + 4, "R3");
        // R8: same-cycle taken update still reads old (empty) entry
        step(PA, 1, 1, PA, 32'h3000, 1, 0, 0, PA + 4, "R8");
        // R2: allocation visible next cycle, counter 10
        look(PA, 1, 1, 32'h3000, "R2");
        // R4: same index, other address
        look(PB, 0, 0, PB + 4, "R4");
        // R8: NT update (10->01) with lookup sees old taken state
        step(PA, 1, 0, PA, 32'h0, 1, 1, 1, 32'h3000, "R8");
        // R6: hit with counter 01
        look(PA, 1, 0, PA + 4, "R6");
        // R5: down to 00, then one taken (01) is not enough
        step(PA, 1, 0, PA, 32'h0, 1, 1, 0, PA + 4, "R5");
        step(PA, 1, 1, PA, 32'h3000, 1, 1, 0, PA + 4, "R5");
        look(PA, 1, 0, PA + 4, "R5");
        // 01 -> 10 with new target; same-cycle lookup sees old
        step(PA, 1, 1, PA, 32'h3400, 1, 1, 0, PA + 4, "R8");
        // R7: new target in use
        look(PA, 1, 1, 32'h3400, "R7");
        // R5: saturate at 11, then one NT keeps taken, second flips
        train(PA, 1, 32'h3400);
        train(PA, 1, 32'h3400);
        train(PA, 0, 32'h0);
        look(PA, 1, 1, 32'h3400, "R5");
        train(PA, 0, 32'h0);
        look(PA, 1, 0, PA + 4, "R5");
        // R9: conflicting taken miss evicts, counter starts at 10
        train(PB, 1, 32'h5000);
        look(PB, 1, 1, 32'h5000, "R9");
        look(PA, 0, 0, PA + 4, "R9");
        train(PB, 0, 32'h0);
        look(PB, 1, 0, PB + 4, "R9");
        look(PC, 0, 0, PC + 4, "R4");
        // R1: reset mid-run clears entries
        @(posedge clk);
        #1 rst = 1'b1; upd_valid = 1'b0;
        @(posedge clk);
        #1 rst = 1'b0;
        look(PB, 0, 0, PB + 4, "R1");
        @(posedge clk);
        @(posedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule